// File: doc/BRIEF.md
# Timer Event Status and Interrupt Unit

This block gathers the event strobes of one 16-bit timer/counter channel into a status word. The strobes cover counter overflow, compare matches on registers A, B and C, captures into A and B, and an external trigger. Each event sets a sticky flag, and a read of the status word clears the flags. The same status word also shows three live levels: the clock-enabled state and the two I/O line levels. A programmable mask selects which flags drive the single interrupt request.

A mode level selects capture or waveform operation. Only flags that make sense in the current mode can set or read as 1. In capture mode, the block tracks for each capture register whether it has been loaded and not yet read. A second load before that register is read raises the load overrun flag. The register file that holds the capture values decodes the capture-register reads and passes them in as strobes. The counter value is passed through for a live read. A simple strobe bus gives access to the status, enable, disable, mask and counter words.

Top module: `tmr_evt_irq`

## Requirements
- R1: After reset the sticky flags, the mask and `irq_o` are all 0. A status read with the clock-enable and line inputs low returns 0.
- R2: Sticky status bits are: 0 overflow, 1 load overrun, 2 compare A, 3 compare B, 4 compare C, 5 capture A, 6 capture B, 7 external trigger. An event sets its bit from the next cycle onward. The bit holds until a status read (address 0) and is 0 after that read.
- R3: An event strobe in the same cycle as a status read is not lost. That read returns the old value, and the flag is set afterwards.
- R4: Mode gating (`mode_wave_i`: 0 capture, 1 waveform). Compare A and compare B set and read only in waveform mode. Capture A, capture B and load overrun set and read only in capture mode. Overflow, compare C and external trigger are recorded in both modes.
- R5: In capture mode, each capture register has an unread marker. A load sets the marker and a read strobe for that register clears it. A load while the marker is set raises bit 1. When a load and a read of the same register fall in one cycle, the read counts as first: no overrun, and the marker stays set.
- R6: Status bit 16 shows `clk_en_i` live. Bits 17 and 18 show line A and line B live. In capture mode these are the pin levels, and in waveform mode they are the driven levels.
- R7: A write to address 1 sets the mask bits written as 1. A write to address 2 clears the mask bits written as 1. Zero bits leave the mask unchanged. Address 3 reads the mask in bits 7:0.
- R8: `irq_o` is 1 while any visible sticky flag has its mask bit set.
- R9: Address 4 reads the live counter value in the low 16 bits.
- R10: `rdata_o` is 0 when `rd_i` is low and for unmapped addresses. Status bits 15:8 and 31:19 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wave_i | input | 1 | 0 capture mode, 1 waveform mode |
| clk_en_i | input | 1 | Channel clock enabled level |
| line_a_pin_i | input | 1 | Line A input pin level |
| line_b_pin_i | input | 1 | Line B input pin level |
| line_a_drv_i | input | 1 | Line A driven output level |
| line_b_drv_i | input | 1 | Line B driven output level |
| cnt_i | input | 16 | Live counter value |
| ovf_i | input | 1 | Counter overflow strobe |
| cmp_a_i | input | 1 | Compare A match strobe |
| cmp_b_i | input | 1 | Compare B match strobe |
| cmp_c_i | input | 1 | Compare C match strobe |
| cap_a_i | input | 1 | Capture into A strobe |
| cap_b_i | input | 1 | Capture into B strobe |
| ext_trg_i | input | 1 | External trigger strobe |
| cap_a_rd_i | input | 1 | Capture register A is being read |
| cap_b_rd_i | input | 1 | Capture register B is being read |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that every input is at a known level at each rising edge. They also assume that `rd_i` and `addr_i` describe one access per cycle, so a status read and a mask write are never counted in the same cycle. The stimulus meets this by changing every input only on the falling clock edge. It keeps `mode_wave_i` steady from an event pulse to the read that follows it. It issues one bus access per cycle and always pairs an address with a single strobe.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int EVT_N  = 8;
  localparam int ADDR_W = 3;

  localparam int B_OVF  = 0;
  localparam int B_OVR  = 1;
  localparam int B_CMPA = 2;
  localparam int B_CMPB = 3;
  localparam int B_CMPC = 4;
  localparam int B_CAPA = 5;
  localparam int B_CAPB = 6;
  localparam int B_EXT  = 7;
  localparam int B_CLKEN = 16;
  localparam int B_LINA  = 17;
  localparam int B_LINB  = 18;

  localparam logic [EVT_N-1:0] WAVE_ONLY = 8'h0C;
  localparam logic [EVT_N-1:0] CAPT_ONLY = 8'h62;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 3'd0,
    A_MEN  = 3'd1,
    A_MDIS = 3'd2,
    A_MASK = 3'd3,
    A_CNT  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/tmr_evt_gate.sv
module tmr_evt_gate
  import tmr_evt_pkg::*;
#(
  parameter int CAP_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wave_i,
  input  logic             ovf_i,
  input  logic             cmp_a_i,
  input  logic             cmp_b_i,
  input  logic             cmp_c_i,
  input  logic [CAP_N-1:0] cap_i,
  input  logic [CAP_N-1:0] cap_rd_i,
  input  logic             ext_trg_i,
  output logic [EVT_N-1:0] set_o
);
  logic [CAP_N-1:0] load, unread_q, ovr;

  assign load = cap_i & {CAP_N{~mode_wave_i}};

  for (genvar g = 0; g < CAP_N; g++) begin : g_trk
    logic trk_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        trk_q <= 1'b0;
      else if (load[g])   trk_q <= 1'b1;
      else if (cap_rd_i[g]) trk_q <= 1'b0;
    end
    assign unread_q[g] = trk_q;
    // read in the same cycle is taken as happening before the load
    assign ovr[g] = load[g] & unread_q[g] & ~cap_rd_i[g];
  end

  always_comb begin
    set_o         = '0;
    set_o[B_OVF]  = ovf_i;
    set_o[B_OVR]  = |ovr;
    set_o[B_CMPA] = cmp_a_i & mode_wave_i;
    set_o[B_CMPB] = cmp_b_i & mode_wave_i;
    set_o[B_CMPC] = cmp_c_i;
    set_o[B_CAPA] = load[0];
    set_o[B_CAPB] = load[1];
    set_o[B_EXT]  = ext_trg_i;
  end
endmodule

// File: rtl/tmr_evt_sticky.sv
module tmr_evt_sticky #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) f_q <= 1'b0;
      else         f_q <= set_i[i] | (f_q & ~clr_i);
    end
    assign flags_o[i] = f_q;
  end
endmodule

// File: rtl/tmr_irq_mask.sv
module tmr_irq_mask #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_wr_i,
  input  logic         dis_wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (en_wr_i)  mask_d = mask_d | wdata_i;
    if (dis_wr_i) mask_d = mask_d & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(pend_i & mask_q);
endmodule

// File: rtl/tmr_evt_irq.sv
module tmr_evt_irq
  import tmr_evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wave_i,
  input  logic              clk_en_i,
  input  logic              line_a_pin_i,
  input  logic              line_b_pin_i,
  input  logic              line_a_drv_i,
  input  logic              line_b_drv_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ovf_i,
  input  logic              cmp_a_i,
  input  logic              cmp_b_i,
  input  logic              cmp_c_i,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic              ext_trg_i,
  input  logic              cap_a_rd_i,
  input  logic              cap_b_rd_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [EVT_N-1:0] set_vec, flags_q, vis, mask_q;
  logic             stat_rd, men_wr, mdis_wr;
  logic             line_a, line_b;
  logic [DATA_W-1:0] stat_word;

  assign stat_rd = rd_i & (addr_i == A_STAT);
  assign men_wr  = wr_i & (addr_i == A_MEN);
  assign mdis_wr = wr_i & (addr_i == A_MDIS);

  tmr_evt_gate #(.CAP_N(2)) i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wave_i(mode_wave_i),
    .ovf_i      (ovf_i),
    .cmp_a_i    (cmp_a_i),
    .cmp_b_i    (cmp_b_i),
    .cmp_c_i    (cmp_c_i),
    .cap_i      ({cap_b_i, cap_a_i}),
    .cap_rd_i   ({cap_b_rd_i, cap_a_rd_i}),
    .ext_trg_i  (ext_trg_i),
    .set_o      (set_vec)
  );

  tmr_evt_sticky #(.N(EVT_N)) i_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (stat_rd),
    .flags_o(flags_q)
  );

  // flags of the other mode are hidden from reads and from the interrupt
  assign vis = flags_q & (mode_wave_i ? ~CAPT_ONLY : ~WAVE_ONLY);

  tmr_irq_mask #(.N(EVT_N)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_wr_i (men_wr),
    .dis_wr_i(mdis_wr),
    .wdata_i (wdata_i[EVT_N-1:0]),
    .pend_i  (vis),
    .mask_o  (mask_q),
    .irq_o   (irq_o)
  );

  assign line_a = mode_wave_i ? line_a_drv_i : line_a_pin_i;
  assign line_b = mode_wave_i ? line_b_drv_i : line_b_pin_i;

  always_comb begin
    stat_word              = '0;
    stat_word[EVT_N-1:0]   = vis;
    stat_word[B_CLKEN]     = clk_en_i;
    stat_word[B_LINA]      = line_a;
    stat_word[B_LINB]      = line_b;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        A_STAT:  rdata_o = stat_word;
        A_MASK:  rdata_o[EVT_N-1:0] = mask_q;
        A_CNT:   rdata_o[CNT_W-1:0] = cnt_i;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_evt_irq_chk.sv
module tmr_evt_irq_chk
  import tmr_evt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_wave_i,
  input logic              clk_en_i,
  input logic              ovf_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic [EVT_N-1:0]  flags_q,
  input logic [EVT_N-1:0]  mask_q
);
  logic stat_rd;
  assign stat_rd = rd_i && (addr_i == A_STAT);

  a_r2_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  a_r3_evt_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && ovf_i) |=> flags_q[B_OVF]);

  a_r4_no_cmp_in_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !mode_wave_i) |-> (rdata_o[B_CMPB:B_CMPA] == 2'b00));

  a_r4_no_cap_in_wave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && mode_wave_i) |-> (rdata_o[B_CAPB:B_CAPA] == 2'b00));

  a_r5_no_ovr_in_wave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && mode_wave_i) |-> !rdata_o[B_OVR]);

  a_r6_clken_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |-> (rdata_o[B_CLKEN] == clk_en_i));

  a_r7_mask_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_MEN) |=>
      ((mask_q & $past(wdata_i[EVT_N-1:0])) == $past(wdata_i[EVT_N-1:0])));

  a_r8_irq_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && |(rdata_o[EVT_N-1:0] & mask_q)) |-> irq_o);

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == 32'd0));
endmodule

bind tmr_evt_irq tmr_evt_irq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_wave_i(mode_wave_i),
  .clk_en_i   (clk_en_i),
  .ovf_i      (ovf_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .flags_q    (flags_q),
  .mask_q     (mask_q)
);

// File: tb/test_tmr_evt_irq.sv
module test_tmr_evt_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wave = 1'b0, clk_en = 1'b0;
  logic la_pin = 1'b0, lb_pin = 1'b0, la_drv = 1'b0, lb_drv = 1'b0;
  logic [15:0] cnt = '0;
  logic ovf = 0, cmp_a = 0, cmp_b = 0, cmp_c = 0, cap_a = 0, cap_b = 0, ext = 0;
  logic cap_a_rd = 0, cap_b_rd = 0;
  logic rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_evt_irq i_tmr_evt_irq (
    .clk_i(clk), .rst_ni(rst_n), .mode_wave_i(mode_wave), .clk_en_i(clk_en),
    .line_a_pin_i(la_pin), .line_b_pin_i(lb_pin),
    .line_a_drv_i(la_drv), .line_b_drv_i(lb_drv), .cnt_i(cnt),
    .ovf_i(ovf), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cmp_c_i(cmp_c),
    .cap_a_i(cap_a), .cap_b_i(cap_b), .ext_trg_i(ext),
    .cap_a_rd_i(cap_a_rd), .cap_b_rd_i(cap_b_rd),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // {mode, events[6:0] = ext,cap_b,cap_a,cmp_c,cmp_b,cmp_a,ovf, expected sticky byte}
  localparam logic [15:0] VEC [12] = '{
    {1'b0, 7'h01, 8'h01}, {1'b0, 7'h02, 8'h00}, {1'b0, 7'h04, 8'h00},
    {1'b0, 7'h08, 8'h10}, {1'b0, 7'h40, 8'h80}, {1'b1, 7'h06, 8'h0C},
    {1'b1, 7'h10, 8'h00}, {1'b1, 7'h49, 8'h91}, {1'b0, 7'h10, 8'h20},
    {1'b0, 7'h20, 8'h40}, {1'b0, 7'h7F, 8'hF1}, {1'b1, 7'h7F, 8'h9D}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ev(input logic [6:0] e);
    {ext, cap_b, cap_a, cmp_c, cmp_b, cmp_a, ovf} = e;
  endtask

  task automatic pulse(input logic [6:0] e);
    set_ev(e);
    @(negedge clk);
    set_ev(7'h00);
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    rd = 1; addr = a; #1 d = rdata;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0; wdata = '0;
  endtask

  task automatic clr_trk();
    cap_a_rd = 1; cap_b_rd = 1;
    @(negedge clk);
    cap_a_rd = 0; cap_b_rd = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10
    bus_rd(3'd0, d); check("R1 status after reset", d, 32'h0);
    bus_rd(3'd3, d); check("R1 mask after reset", d, 32'h0);
    #1 check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2 / R4 vector table
    foreach (VEC[i]) begin
      mode_wave = VEC[i][15];
      pulse(VEC[i][14:8]);
      bus_rd(3'd0, d);
      check($sformatf("R2 R4 vector %0d", i), {24'b0, d[7:0]}, {24'b0, VEC[i][7:0]});
      bus_rd(3'd0, d);
      check($sformatf("R2 cleared vector %0d", i), {24'b0, d[7:0]}, 32'h0);
      clr_trk();
    end
    mode_wave = 1'b0;

    // R3 event during status read
    set_ev(7'h01); rd = 1; addr = 3'd0; #1 d = rdata;
    check("R3 read returns old", {31'b0, d[0]}, 32'h0);
    @(negedge clk); rd = 0; set_ev(7'h00);
    bus_rd(3'd0, d); check("R3 flag kept", {24'b0, d[7:0]}, 32'h01);

    // R5 overrun
    pulse(7'h10); pulse(7'h10);
    bus_rd(3'd0, d); check("R5 double load A", {24'b0, d[7:0]}, 32'h22);
    clr_trk();
    pulse(7'h10); cap_a_rd = 1; @(negedge clk); cap_a_rd = 0; pulse(7'h10);
    bus_rd(3'd0, d); check("R5 read between loads", {24'b0, d[7:0]}, 32'h20);
    clr_trk();
    pulse(7'h20); pulse(7'h20);
    bus_rd(3'd0, d); check("R5 double load B", {24'b0, d[7:0]}, 32'h42);
    clr_trk();
    pulse(7'h10);
    cap_a_rd = 1; set_ev(7'h10); @(negedge clk); cap_a_rd = 0; set_ev(7'h00);
    bus_rd(3'd0, d); check("R5 read with load same cycle", {24'b0, d[7:0]}, 32'h20);
    pulse(7'h10);
    bus_rd(3'd0, d); check("R5 marker kept after same cycle", {24'b0, d[7:0]}, 32'h22);
    clr_trk();

    // R6 live bits
    clk_en = 1; la_pin = 1; lb_pin = 0; la_drv = 0; lb_drv = 1;
    bus_rd(3'd0, d); check("R6 capture lines", d, 32'h0003_0000);
    mode_wave = 1;
    bus_rd(3'd0, d); check("R6 waveform lines", d, 32'h0005_0000);
    mode_wave = 0; clk_en = 0; la_pin = 0; lb_drv = 0;

    // R7 mask writes
    bus_wr(3'd1, 32'h05);
    bus_rd(3'd3, d); check("R7 enable", d, 32'h05);
    bus_wr(3'd1, 32'h00);
    bus_rd(3'd3, d); check("R7 zero enable no effect", d, 32'h05);
    bus_wr(3'd2, 32'h01);
    bus_rd(3'd3, d); check("R7 disable", d, 32'h04);
    bus_wr(3'd1, 32'hFFFF_FFFF);
    bus_rd(3'd3, d); check("R7 enable all", d, 32'hFF);
    bus_wr(3'd2, 32'hFFFF_FFFF);
    bus_rd(3'd3, d); check("R7 disable all", d, 32'h00);

    // R8 interrupt
    bus_wr(3'd1, 32'h10);
    pulse(7'h01);
    #1 check("R8 unmasked flag no irq", {31'b0, irq}, 32'h0);
    pulse(7'h08);
    #1 check("R8 masked flag irq", {31'b0, irq}, 32'h1);
    bus_rd(3'd0, d);
    #1 check("R8 irq drops after read", {31'b0, irq}, 32'h0);
    bus_wr(3'd1, 32'h04);
    mode_wave = 1; pulse(7'h02); mode_wave = 0;
    #1 check("R8 R4 hidden flag no irq", {31'b0, irq}, 32'h0);
    bus_rd(3'd0, d);
    bus_wr(3'd2, 32'hFF);

    // R9 counter
    cnt = 16'hBEEF;
    bus_rd(3'd4, d); check("R9 counter read", d, 32'h0000_BEEF);

    // R10 unmapped and idle
    bus_rd(3'd7, d); check("R10 unmapped read", d, 32'h0);
    #1 check("R10 idle rdata", rdata, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule